// File: doc/BRIEF.md
# Stereo Census Matching-Cost Engine

This block takes two rectified 8-bit pixel streams, one from each camera, that share a clock and arrive pixel-aligned in raster order. It keeps six previous rows of each image in line memories. With the incoming row, these rows form a 7x7 neighbourhood around every pixel. From each neighbourhood it derives a 48-bit census signature. For every pixel of the left (reference) image it emits a vector of NDISP matching costs. Candidate d is the Hamming distance between the left signature at column x and the right signature at column x-d. A cost-aggregation stage placed after this block consumes the vector at pixel rate.

A small controller tracks the frame. It has four states. IDLE waits for a start-of-frame pixel. FILL accepts the first 3W+3 pixels, which have no complete centre yet. STREAM emits one cost vector per accepted pixel. DRAIN emits the last 3W+3 vectors on its own, from internally generated padding pixels. The transitions are:
- IDLE->FILL: on a valid pixel flagged as start of frame.
- FILL->STREAM: after pixel 3W+2 is accepted.
- STREAM->DRAIN: after pixel W*H-1 is accepted.
- DRAIN->IDLE: after the final padding pixel.

Where a candidate cannot be formed, the cost is forced to 48 and the candidate's invalid bit is set. This happens when a neighbourhood would cross the image edge.

Top module: `census_cost_engine`

## Requirements
- R1: While reset is low and after it is released, out_valid, out_sof and out_sol are 0. No vector is emitted until a start-of-frame pixel has been accepted.
- R2: Each census bit is 1 when its neighbour is strictly less than the window centre. The 48 bits cover the non-centre window pixels in raster order, with the top-left pixel at bit 47 and the bottom-right at bit 0. A cost is the number of differing bits between two signatures, a 6-bit value from 0 to 48.
- R3: Lane d of out_cost, at bits [6d+5:6d], holds the cost between the left signature centred at column x and the right signature centred at column x-d on the same row.
- R4: For centre row y and column x, lane d is forced to 48 and out_invalid bit d is set when any of these holds: y<3, y>H-4, x<3, x>W-4, or x-d<3. Otherwise the bit is 0.
- R5: Vectors come out in raster order, exactly W*H per frame. The vector for centre index k is presented after the clock edge that follows the edge accepting input pixel k+3W+3.
- R6: out_sof is high only with the vector for centre (0,0). out_sol is high exactly with vectors whose centre column is 0.
- R7: In IDLE, valid pixels without the start-of-frame flag are discarded and leave no trace in later results.
- R8: A start-of-frame flag on a pixel in the middle of a frame has no effect; the pixel is used as ordinary data.
- R9: After the last pixel of a frame, the remaining 3W+3 vectors follow on consecutive cycles with no input. Pixels offered during this drain are discarded, and the block then returns to IDLE.
- R10: Cycles with in_valid low pause the pipeline without changing any emitted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock shared by both streams |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A pixel pair is present this cycle |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_left | input | PIX_W | Left (reference) pixel |
| in_right | input | PIX_W | Right pixel |
| out_valid | output | 1 | A cost vector is present |
| out_sof | output | 1 | Vector belongs to centre (0,0) |
| out_sol | output | 1 | Vector belongs to centre column 0 |
| out_cost | output | NDISP*6 | Cost of candidate d in bits [6d+5:6d] |
| out_invalid | output | NDISP | Candidate d forced to maximum cost |

## Verification
The tightest overlap is where the drain of one frame meets the start of the next. In the same cycles that the block emits padded border vectors without input, a source may already offer start-of-frame pixels. The bench provokes this by presenting flagged pixels on every drain cycle. It then judges the result in three ways:
- The last vector must land exactly 3W+3 cycles after the drain begins.
- No extra vector may appear.
- The following frame, which starts properly after the drain, must match the reference model column for column, so any pixel wrongly absorbed during the drain shows up as misaligned costs.

// File: rtl/cen_pkg.sv
package cen_pkg;
    localparam int WIN      = 7;
    localparam int HALF     = 3;
    localparam int CEN_BITS = WIN * WIN - 1;
    localparam int COST_W   = 6;
    localparam int COST_MAX = CEN_BITS;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_STREAM,
        ST_DRAIN
    } cen_state_e;
endpackage

// File: rtl/cen_window.sv
module cen_window
    import cen_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int IMG_W = 64,
    localparam int COL_W = $clog2(IMG_W)
) (
    input  logic                clk,
    input  logic                adv,
    input  logic [COL_W-1:0]    col,
    input  logic [PIX_W-1:0]    pix_in,
    output logic [CEN_BITS-1:0] census
);
    localparam int STORED = WIN - 1;
    localparam int CIDX   = HALF * WIN + HALF;

    logic [STORED*PIX_W-1:0] lb_mem [IMG_W];
    logic [STORED*PIX_W-1:0] rd_word;
    logic [STORED*PIX_W-1:0] wr_word;
    logic [PIX_W-1:0]        stack [WIN];
    logic [PIX_W-1:0]        win   [WIN][WIN];

    assign rd_word = lb_mem[col];

    always_comb begin
        for (int k = 0; k < STORED; k++) begin
            stack[k] = rd_word[k*PIX_W +: PIX_W];
        end
        stack[WIN-1] = pix_in;
        for (int k = 0; k < STORED; k++) begin
            wr_word[k*PIX_W +: PIX_W] = stack[k+1];
        end
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            lb_mem[col] <= wr_word;
            for (int k = 0; k < WIN; k++) begin
                for (int j = 0; j < WIN - 1; j++) begin
                    win[k][j] <= win[k][j+1];
                end
                win[k][WIN-1] <= stack[k];
            end
        end
    end

    always_comb begin
        census = '0;
        for (int k = 0; k < WIN; k++) begin
            for (int j = 0; j < WIN; j++) begin
                if (k * WIN + j < CIDX) begin
                    census[CEN_BITS - 1 - (k * WIN + j)] = (win[k][j] < win[HALF][HALF]);
                end else if (k * WIN + j > CIDX) begin
                    census[CEN_BITS - (k * WIN + j)] = (win[k][j] < win[HALF][HALF]);
                end
            end
        end
    end
endmodule

// File: rtl/cen_lane.sv
module cen_lane
    import cen_pkg::*;
(
    input  logic [CEN_BITS-1:0] cen_a,
    input  logic [CEN_BITS-1:0] cen_b,
    input  logic                force_max,
    output logic [COST_W-1:0]   cost
);
    logic [CEN_BITS-1:0] diff;
    logic [COST_W-1:0]   ones;

    always_comb begin
        diff = cen_a ^ cen_b;
        ones = '0;
        for (int i = 0; i < CEN_BITS; i++) begin
            ones = ones + COST_W'(diff[i]);
        end
        cost = force_max ? COST_W'(COST_MAX) : ones;
    end
endmodule

// File: rtl/cen_ctrl.sv
module cen_ctrl
    import cen_pkg::*;
#(
    parameter int IMG_W = 64,
    parameter int IMG_H = 48,
    localparam int COL_W = $clog2(IMG_W),
    localparam int ROW_W = $clog2(IMG_H)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    output logic             adv,
    output logic             emit,
    output logic             draining,
    output logic [COL_W-1:0] col,
    output logic [COL_W-1:0] ctr_x,
    output logic [ROW_W-1:0] ctr_y
);
    localparam int LAT   = HALF * IMG_W + HALF;
    localparam int NPIX  = IMG_W * IMG_H;
    localparam int TOTAL = NPIX + LAT;
    localparam int CNT_W = $clog2(TOTAL + 1);

    cen_state_e       state_q, state_d;
    logic [CNT_W-1:0] pix_q;
    logic [COL_W-1:0] col_q;
    logic [COL_W-1:0] cx_q;
    logic [ROW_W-1:0] cy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        adv     = 1'b0;
        emit    = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                adv = in_valid && in_sof;
                if (adv) state_d = ST_FILL;
            end
            ST_FILL: begin
                adv = in_valid;
                if (adv && pix_q == CNT_W'(LAT - 1)) state_d = ST_STREAM;
            end
            ST_STREAM: begin
                adv  = in_valid;
                emit = in_valid;
                if (adv && pix_q == CNT_W'(NPIX - 1)) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                adv  = 1'b1;
                emit = 1'b1;
                if (pix_q == CNT_W'(TOTAL - 1)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q <= '0;
            col_q <= '0;
            cx_q  <= '0;
            cy_q  <= '0;
        end else begin
            if (adv) begin
                if (state_d == ST_IDLE) begin
                    pix_q <= '0;
                    col_q <= '0;
                end else begin
                    pix_q <= pix_q + 1'b1;
                    col_q <= (col_q == COL_W'(IMG_W - 1)) ? '0 : col_q + 1'b1;
                end
            end
            if (emit) begin
                if (state_d == ST_IDLE) begin
                    cx_q <= '0;
                    cy_q <= '0;
                end else if (cx_q == COL_W'(IMG_W - 1)) begin
                    cx_q <= '0;
                    cy_q <= (cy_q == ROW_W'(IMG_H - 1)) ? '0 : cy_q + 1'b1;
                end else begin
                    cx_q <= cx_q + 1'b1;
                end
            end
        end
    end

    assign draining = (state_q == ST_DRAIN);
    assign col      = col_q;
    assign ctr_x    = cx_q;
    assign ctr_y    = cy_q;

    // R9: the drain keeps stepping through padding pixels without any input
    a_r9_drain_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |=> (pix_q != $past(pix_q)));
endmodule

// File: rtl/census_cost_engine.sv
module census_cost_engine
    import cen_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int IMG_W = 64,
    parameter int IMG_H = 48,
    parameter int NDISP = 32,
    localparam int COL_W = $clog2(IMG_W),
    localparam int ROW_W = $clog2(IMG_H)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic [PIX_W-1:0]        in_left,
    input  logic [PIX_W-1:0]        in_right,
    output logic                    out_valid,
    output logic                    out_sof,
    output logic                    out_sol,
    output logic [NDISP*COST_W-1:0] out_cost,
    output logic [NDISP-1:0]        out_invalid
);
    logic             adv, emit, draining;
    logic [COL_W-1:0] col, ctr_x;
    logic [ROW_W-1:0] ctr_y;
    logic [PIX_W-1:0] feed_l, feed_r;

    cen_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .adv      (adv),
        .emit     (emit),
        .draining (draining),
        .col      (col),
        .ctr_x    (ctr_x),
        .ctr_y    (ctr_y)
    );

    // padding pixels during the drain are zero; their windows are always forced
    assign feed_l = draining ? '0 : in_left;
    assign feed_r = draining ? '0 : in_right;

    logic [CEN_BITS-1:0] cen_l, cen_r;

    cen_window #(.PIX_W(PIX_W), .IMG_W(IMG_W)) u_win_l (
        .clk(clk), .adv(adv), .col(col), .pix_in(feed_l), .census(cen_l)
    );
    cen_window #(.PIX_W(PIX_W), .IMG_W(IMG_W)) u_win_r (
        .clk(clk), .adv(adv), .col(col), .pix_in(feed_r), .census(cen_r)
    );

    logic             a0, e0;
    logic [COL_W-1:0] x0;
    logic [ROW_W-1:0] y0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a0 <= 1'b0;
            e0 <= 1'b0;
            x0 <= '0;
            y0 <= '0;
        end else begin
            a0 <= adv;
            e0 <= emit;
            x0 <= ctr_x;
            y0 <= ctr_y;
        end
    end

    // right signatures of the previous NDISP-1 columns
    logic [CEN_BITS-1:0] rdl  [NDISP-1];
    logic [CEN_BITS-1:0] cand [NDISP];
    logic [COST_W-1:0]   lane_cost [NDISP];
    logic [NDISP-1:0]    force_v;
    logic                border;

    always_ff @(posedge clk) begin
        if (a0) begin
            rdl[0] <= cen_r;
            for (int k = 1; k < NDISP - 1; k++) begin
                rdl[k] <= rdl[k-1];
            end
        end
    end

    assign border = (int'(y0) < HALF) || (int'(y0) > IMG_H - 1 - HALF) ||
                    (int'(x0) < HALF) || (int'(x0) > IMG_W - 1 - HALF);

    for (genvar g = 0; g < NDISP; g++) begin : g_lane
        if (g == 0) begin : g_tap0
            assign cand[g] = cen_r;
        end else begin : g_tapn
            assign cand[g] = rdl[g-1];
        end
        assign force_v[g] = border || (int'(x0) < HALF + g);
        cen_lane u_lane (
            .cen_a     (cen_l),
            .cen_b     (cand[g]),
            .force_max (force_v[g]),
            .cost      (lane_cost[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_sof     <= 1'b0;
            out_sol     <= 1'b0;
            out_cost    <= '0;
            out_invalid <= '0;
        end else begin
            out_valid <= a0 && e0;
            out_sof   <= a0 && e0 && (x0 == '0) && (y0 == '0);
            out_sol   <= a0 && e0 && (x0 == '0);
            if (a0 && e0) begin
                for (int d = 0; d < NDISP; d++) begin
                    out_cost[d*COST_W +: COST_W] <= lane_cost[d];
                end
                out_invalid <= force_v;
            end
        end
    end

    // R6: frame start only with a valid first-column vector
    a_r6_sof_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_sol && out_valid));

    // R4: centre column 0 leaves no usable candidate
    a_r4_left_edge_forced: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> (&out_invalid));

    // R5: every vector stems from an emitting pixel two edges earlier
    a_r5_pixel_to_output: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(emit, 2));

    // R9: each drain cycle yields a vector one edge later
    a_r9_drain_output: assert property (@(posedge clk) disable iff (!rst_n)
        (draining && a0) |=> out_valid);

    // R4: a larger shift can never make a forced candidate usable
    for (genvar m = 0; m < NDISP - 1; m++) begin : g_mono
        a_r4_mask_monotone: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_invalid[m]) |-> out_invalid[m+1]);
    end
endmodule

// File: tb/test_census_cost_engine.sv
module test_census_cost_engine;
    localparam int W    = 20;
    localparam int H    = 9;
    localparam int D    = 8;
    localparam int PW   = 8;
    localparam int LAT  = 3 * W + 3;
    localparam int NPIX = W * H;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sof = 1'b0;
    logic [PW-1:0] in_left = '0;
    logic [PW-1:0] in_right = '0;
    logic          out_valid, out_sof, out_sol;
    logic [D*6-1:0] out_cost;
    logic [D-1:0]  out_invalid;

    census_cost_engine #(.PIX_W(PW), .IMG_W(W), .IMG_H(H), .NDISP(D)) i_census_cost_engine (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
        .out_sof(out_sof), .out_sol(out_sol), .out_cost(out_cost),
        .out_invalid(out_invalid)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    int img_l [H][W];
    int img_r [H][W];
    int mon_idx = 0;
    int lat_cyc = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [47:0] bcen(input bit rside, input int y, input int x);
        logic [47:0] c;
        int b, ctr, v;
        c = '0;
        b = 47;
        ctr = rside ? img_r[y][x] : img_l[y][x];
        for (int ky = -3; ky <= 3; ky++) begin
            for (int kx = -3; kx <= 3; kx++) begin
                if (!(ky == 0 && kx == 0)) begin
                    v = rside ? img_r[y+ky][x+kx] : img_l[y+ky][x+kx];
                    c[b] = (v < ctr);
                    b--;
                end
            end
        end
        return c;
    endfunction

    function automatic bit exp_forced(input int y, input int x, input int d);
        return (y < 3) || (y > H - 4) || (x < 3) || (x > W - 4) || (x - d < 3);
    endfunction

    function automatic int exp_cost(input int y, input int x, input int d);
        if (exp_forced(y, x, d)) return 48;
        return $countones(bcen(1'b0, y, x) ^ bcen(1'b1, y, x - d));
    endfunction

    // output monitor: compares every vector with the model
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (mon_idx >= NPIX) begin
                chk(1'b0, "R5", "vector beyond frame size", mon_idx, NPIX - 1);
            end else begin
                automatic int y = mon_idx / W;
                automatic int x = mon_idx % W;
                chk(out_sof == (mon_idx == 0), "R6", "out_sof", out_sof, mon_idx == 0);
                chk(out_sol == (x == 0), "R6", "out_sol", out_sol, x == 0);
                if (mon_idx == 0)
                    chk(cyc == lat_cyc + 2, "R5", "first vector cycle", cyc, lat_cyc + 2);
                for (int d = 0; d < D; d++) begin
                    automatic int ec = exp_cost(y, x, d);
                    automatic bit ef = exp_forced(y, x, d);
                    chk(int'(out_cost[d*6 +: 6]) == ec, ef ? "R4" : "R3 R2",
                        $sformatf("cost y=%0d x=%0d d=%0d", y, x, d), out_cost[d*6 +: 6], ec);
                    chk(out_invalid[d] == ef, "R4",
                        $sformatf("invalid y=%0d x=%0d d=%0d", y, x, d), out_invalid[d], ef);
                end
            end
            mon_idx++;
        end
    end

    task automatic fill(input int pattern);
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                case (pattern)
                    0: begin img_l[y][x] = $urandom % 256; img_r[y][x] = $urandom % 256; end
                    1: begin img_l[y][x] = 77; img_r[y][x] = 77; end
                    2: img_l[y][x] = $urandom % 256;
                    default: begin
                        img_l[y][x] = (x * 13 + y * 7) % 256;
                        img_r[y][x] = (x * 11 + y * 5 + 40) % 256;
                    end
                endcase
            end
        end
        if (pattern == 2) begin
            for (int y = 0; y < H; y++)
                for (int x = 0; x < W; x++)
                    img_r[y][x] = img_l[y][(x + 3 < W) ? x + 3 : W - 1];
        end
    endtask

    // drives one frame, then checks the drain timing (R9)
    task automatic run_frame(input int stall_pct, input bit mid_sof, input bit drain_noise);
        mon_idx = 0;
        for (int p = 0; p < NPIX; p++) begin
            if (stall_pct > 0) begin
                while (($urandom % 100) < stall_pct) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_sof   = 1'b1;
                    in_left  = PW'($urandom);
                    in_right = PW'($urandom);
                end
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (p == 0) || (mid_sof && (p % 37 == 5));
            in_left  = PW'(img_l[p / W][p % W]);
            in_right = PW'(img_r[p / W][p % W]);
            if (p == LAT) lat_cyc = cyc;
        end
        for (int k = 0; k < LAT; k++) begin
            @(negedge clk);
            in_valid = drain_noise;
            in_sof   = drain_noise;
            in_left  = PW'($urandom);
            in_right = PW'($urandom);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        #5;
        chk(mon_idx == NPIX - 1, "R9", "vectors one cycle before drain end", mon_idx, NPIX - 1);
        @(negedge clk);
        #5;
        chk(mon_idx == NPIX, "R9", "vectors at drain end", mon_idx, NPIX);
        repeat (4) @(negedge clk);
        chk(mon_idx == NPIX, "R5", "vectors per frame", mon_idx, NPIX);
    endtask

    task automatic t_reset();
        // R1: quiet outputs during and after reset
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(out_sof == 1'b0, "R1", "out_sof after reset", out_sof, 0);
        chk(out_sol == 1'b0, "R1", "out_sol after reset", out_sol, 0);
    endtask

    task automatic t_idle_discard();
        // R7: pixels without a frame flag while idle must be dropped
        mon_idx = 0;
        for (int k = 0; k < 2 * LAT; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = 1'b0;
            in_left  = PW'($urandom);
            in_right = PW'($urandom);
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(mon_idx == 0, "R7", "vectors from unflagged idle pixels", mon_idx, 0);
        fill(0);
        run_frame(0, 1'b0, 1'b0);
    endtask

    task automatic t_random_frame();
        fill(0);
        run_frame(0, 1'b0, 1'b0);
    endtask

    task automatic t_flat_frame();
        // R2: a flat scene gives all-zero signatures and zero cost where usable
        fill(1);
        run_frame(0, 1'b0, 1'b0);
    endtask

    task automatic t_shift_frame();
        // R3: right image shifted by three columns, lane 3 must match exactly
        fill(2);
        run_frame(0, 1'b0, 1'b0);
    endtask

    task automatic t_stall_frame();
        // R10: random gaps in the input stream
        fill(3);
        run_frame(35, 1'b0, 1'b0);
    endtask

    task automatic t_mid_sof_frame();
        // R8: stray frame flags inside a frame are plain data
        fill(0);
        run_frame(10, 1'b1, 1'b0);
    endtask

    task automatic t_drain_overlap();
        // R9: flagged pixels offered while draining must be ignored
        fill(0);
        run_frame(0, 1'b0, 1'b1);
        fill(3);
        run_frame(0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_idle_discard();
        t_random_frame();
        t_flat_frame();
        t_shift_frame();
        t_stall_frame();
        t_mid_sof_frame();
        t_drain_overlap();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule